// File: doc/BRIEF.md
# Asymmetric Edge Delay Qualifier

This block sits between a combinational sequencing term and an output driver. It passes a single logic level to its output, but delays each rising edge and each falling edge by its own programmed amount. An edge is accepted only if the input keeps its new level for the whole delay. If the input reverts early, the pending edge is dropped and the timer is abandoned. The same block therefore removes glitches and also sets power-up and power-down sequencing delays.

Time is counted in ticks of an externally supplied millisecond enable. One 8-bit timing word holds two 4-bit codes. Each code selects a delay of 0 to 500 ticks from a fixed table. The qualified output is a plain registered level, so it can drive a pin and can also be fed back into other sequencing terms.

Top module: `edge_qualifier`

## Requirements
- R1: While `rstN` is low, `qualOut` is 0 and any pending delay is discarded, whatever the input does.
- R2: `delayCfg[3:0]` is the rise code and `delayCfg[7:4]` is the fall code. A code selects a tick count from this table: 0→0, 1→1, 2→2, 3→5, 4→10, 5→20, 6→30, 7→40, 8→50, 9→75, 10→100, 11→150, 12→200, 13→300, 14→400, 15→500. Code 15 gives 500 ticks.
- R3: Suppose the rise count N is nonzero, `tickMs` is high on every cycle, and `dataIn` is first sampled high at clock edge S. If `dataIn` stays high through edge S+N, `qualOut` goes to 1 at edge S+N.
- R4: If `dataIn` drops before the rise count expires, `qualOut` does not change and the timer is abandoned. The next high period starts counting from zero. A low-going input while `qualOut` is still 0 never starts a fall delay.
- R5: With rise code 0, `qualOut` goes to 1 on the same edge at which `dataIn` is first sampled high. This also holds for a one-cycle pulse.
- R6: With fall code 0, `qualOut` goes to 0 on the same edge at which `dataIn` is first sampled low.
- R7: Suppose the fall count M is nonzero and `dataIn` is first sampled low at edge F while `qualOut` is 1. If the input stays low through edge F+M, `qualOut` falls at edge F+M. If the input returns high before then, `qualOut` stays 1.
- R8: The delay timer advances only on edges where `tickMs` is high. While `tickMs` stays low and both codes are nonzero, `qualOut` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickMs | input | 1 | Delay time base enable, one pulse per tick |
| dataIn | input | 1 | Logic level to be qualified |
| delayCfg | input | 8 | Fall code in [7:4], rise code in [3:0] |
| qualOut | output | 1 | Qualified, delayed level |

## Verification
Each result is due at an edge fixed by the input. A zero-code edge appears on the very edge at which the input is first sampled at its new level. A coded edge appears N ticked edges later. With the divided and stopped tick patterns, the due edge is the N-th edge after the start on which the tick is high. The driver records the edge number at which it first presents each level. From that number it pushes the edge index and level of every output transition it expects. A monitor samples `qualOut` on the falling clock edge. It matches every change against the head of that queue, flags a change that comes early or is not expected, and flags an expected edge that passes without a change. Level checks after each aborted pulse confirm that no edge slipped through.

// File: rtl/edge_qual_pkg.sv
package edge_qual_pkg;

  localparam int CODE_W    = 4;
  localparam int CFG_W     = 2 * CODE_W;
  localparam int MAX_TICKS = 500;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);

  typedef enum logic [1:0] {
    ST_LOW       = 2'd0,
    ST_RISE_WAIT = 2'd1,
    ST_HIGH      = 2'd2,
    ST_FALL_WAIT = 2'd3
  } qualState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClear;
    logic cntInc;
    logic selFall;
  } dpCtrl_t;

  // code to tick count
  function automatic logic [CNT_W-1:0] codeTicks(input logic [CODE_W-1:0] code);
    logic [CNT_W-1:0] t;
    case (code)
      4'd0:    t = CNT_W'(0);
      4'd1:    t = CNT_W'(1);
      4'd2:    t = CNT_W'(2);
      4'd3:    t = CNT_W'(5);
      4'd4:    t = CNT_W'(10);
      4'd5:    t = CNT_W'(20);
      4'd6:    t = CNT_W'(30);
      4'd7:    t = CNT_W'(40);
      4'd8:    t = CNT_W'(50);
      4'd9:    t = CNT_W'(75);
      4'd10:   t = CNT_W'(100);
      4'd11:   t = CNT_W'(150);
      4'd12:   t = CNT_W'(200);
      4'd13:   t = CNT_W'(300);
      4'd14:   t = CNT_W'(400);
      default: t = CNT_W'(MAX_TICKS);
    endcase
    return t;
  endfunction

endpackage

// File: rtl/edge_qual_dp.sv
module edge_qual_dp
  import edge_qual_pkg::*;
#(
  parameter int CW = CODE_W,
  parameter int NW = CNT_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tickMs,
  input  logic [CW-1:0] riseCode,
  input  logic [CW-1:0] fallCode,
  input  dpCtrl_t       ctrl,
  output logic          timerHit,
  output logic          riseZero,
  output logic          fallZero
);

  logic [NW-1:0] tickCnt;
  logic [NW-1:0] target;
  logic [NW:0]   cntPlus;

  assign riseZero = (riseCode == '0);
  assign fallZero = (fallCode == '0);
  assign target   = codeTicks(ctrl.selFall ? fallCode : riseCode);
  assign cntPlus  = {1'b0, tickCnt} + 1'b1;
  // a zero target expires at once; otherwise the tick that reaches it does
  assign timerHit = (target == '0) || (tickMs && (cntPlus >= {1'b0, target}));

  always_ff @(posedge clk) begin
    if (!rstN || ctrl.cntClear) begin
      tickCnt <= '0;
    end else if (ctrl.cntInc && tickMs && !cntPlus[NW]) begin
      tickCnt <= cntPlus[NW-1:0];
    end
  end

endmodule

// File: rtl/edge_qual_ctrl.sv
module edge_qual_ctrl
  import edge_qual_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    dataIn,
  input  logic    timerHit,
  input  logic    riseZero,
  input  logic    fallZero,
  output dpCtrl_t ctrl,
  output logic    qualOut
);

  qualState_t state, stateNext;

  always_comb begin
    stateNext     = state;
    ctrl          = '0;
    case (state)
      ST_LOW: begin
        if (dataIn) begin
          stateNext     = riseZero ? ST_HIGH : ST_RISE_WAIT;
          ctrl.cntClear = 1'b1;
        end
      end
      ST_RISE_WAIT: begin
        ctrl.cntInc = 1'b1;
        if (!dataIn)       stateNext = ST_LOW;
        else if (timerHit) stateNext = ST_HIGH;
      end
      ST_HIGH: begin
        ctrl.selFall = 1'b1;
        if (!dataIn) begin
          stateNext     = fallZero ? ST_LOW : ST_FALL_WAIT;
          ctrl.cntClear = 1'b1;
        end
      end
      default: begin
        ctrl.selFall = 1'b1;
        ctrl.cntInc  = 1'b1;
        if (dataIn)        stateNext = ST_HIGH;
        else if (timerHit) stateNext = ST_LOW;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_LOW;
      qualOut <= 1'b0;
    end else begin
      state   <= stateNext;
      qualOut <= (stateNext == ST_HIGH) || (stateNext == ST_FALL_WAIT);
    end
  end

endmodule

// File: rtl/edge_qualifier.sv
module edge_qualifier
  import edge_qual_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickMs,
  input  logic             dataIn,
  input  logic [CFG_W-1:0] delayCfg,
  output logic             qualOut
);

  dpCtrl_t dpCtrl;
  logic    timerHit;
  logic    riseZero;
  logic    fallZero;

  edge_qual_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .tickMs   (tickMs),
    .riseCode (delayCfg[CODE_W-1:0]),
    .fallCode (delayCfg[CFG_W-1:CODE_W]),
    .ctrl     (dpCtrl),
    .timerHit (timerHit),
    .riseZero (riseZero),
    .fallZero (fallZero)
  );

  edge_qual_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .dataIn   (dataIn),
    .timerHit (timerHit),
    .riseZero (riseZero),
    .fallZero (fallZero),
    .ctrl     (dpCtrl),
    .qualOut  (qualOut)
  );

endmodule

// File: rtl/edge_qualifier_sva.sv
module edge_qualifier_sva
  import edge_qual_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             tickMs,
  input logic             dataIn,
  input logic [CFG_W-1:0] delayCfg,
  input logic             qualOut
);

  logic riseZ, fallZ;
  assign riseZ = (delayCfg[CODE_W-1:0] == '0);
  assign fallZ = (delayCfg[CFG_W-1:CODE_W] == '0);

  a_r1_reset_low: assert property (@(posedge clk) !rstN |=> !qualOut);

  a_r3_rise_needs_high: assert property (@(posedge clk) disable iff (!rstN)
    $rose(qualOut) |-> $past(dataIn));

  a_r7_fall_needs_low: assert property (@(posedge clk) disable iff (!rstN)
    $fell(qualOut) |-> !$past(dataIn));

  a_r5_zero_rise: assert property (@(posedge clk) disable iff (!rstN)
    (!qualOut && dataIn && riseZ) |=> qualOut);

  a_r6_zero_fall: assert property (@(posedge clk) disable iff (!rstN)
    (qualOut && !dataIn && fallZ) |=> !qualOut);

  a_r8_hold_without_tick: assert property (@(posedge clk) disable iff (!rstN)
    (!tickMs && !riseZ && !fallZ) |=> $stable(qualOut));

endmodule

bind edge_qualifier edge_qualifier_sva u_sva (
  .clk      (clk),
  .rstN     (rstN),
  .tickMs   (tickMs),
  .dataIn   (dataIn),
  .delayCfg (delayCfg),
  .qualOut  (qualOut)
);

// File: tb/edge_qualifier_bench.sv
`timescale 1ns/1ps
module edge_qualifier_bench;

  typedef struct {
    int    edgeIdx;
    logic  level;
    string tag;
  } expItem_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickMs = 1'b1;
  logic       dataIn = 1'b0;
  logic [7:0] delayCfg = 8'h00;
  logic       qualOut;

  int cyc = 0;
  int nChecks = 0;
  int nFails = 0;
  int tickMode = 0;   // 0 every edge, 1 every third edge, 2 never
  bit finished = 1'b0;
  logic prevOut = 1'b0;
  expItem_t expQ[$];

  edge_qualifier u_edge_qualifier (
    .clk(clk), .rstN(rstN), .tickMs(tickMs),
    .dataIn(dataIn), .delayCfg(delayCfg), .qualOut(qualOut)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic tickAt(input int e);
    if (tickMode == 0) return 1'b1;
    if (tickMode == 1) return (e % 3) == 0;
    return 1'b0;
  endfunction

  // monitor: compare each output change with the queue head
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (qualOut !== prevOut) begin
        nChecks++;
        if (expQ.size() == 0) begin
          nFails++;
          $display("FAIL unexpected edge at %0d: got %0b expected none", cyc, qualOut);
        end else begin
          if (expQ[0].edgeIdx != cyc || expQ[0].level !== qualOut) begin
            nFails++;
            $display("FAIL %s: edge %0d level %0b, expected edge %0d level %0b",
                     expQ[0].tag, cyc, qualOut, expQ[0].edgeIdx, expQ[0].level);
          end
          void'(expQ.pop_front());
        end
        prevOut = qualOut;
      end
      if (expQ.size() != 0 && expQ[0].edgeIdx < cyc) begin
        nChecks++;
        nFails++;
        $display("FAIL %s: no edge, expected edge %0d level %0b",
                 expQ[0].tag, expQ[0].edgeIdx, expQ[0].level);
        void'(expQ.pop_front());
      end
    end
  end

  // driver: present a level for n edges, optionally expecting an output edge
  task automatic step(input logic v, input int n, input int expAfter, input string tag);
    expItem_t it;
    dataIn = v;
    if (expAfter >= 0) begin
      it.edgeIdx = cyc + 1 + expAfter;
      it.level   = v;
      it.tag     = tag;
      expQ.push_back(it);
    end
    for (int i = 0; i < n; i++) begin
      tickMs = tickAt(cyc + 1);
      @(negedge clk);
    end
  endtask

  task automatic checkLevel(input logic exp, input string tag);
    nChecks++;
    if (qualOut !== exp) begin
      nFails++;
      $display("FAIL %s: level %0b expected %0b", tag, qualOut, exp);
    end
  endtask

  task automatic finish();
    finished = 1'b1;
    nChecks++;
    if (expQ.size() != 0) begin
      nFails++;
      $display("FAIL pending: %0d edges missing, expected 0", expQ.size());
    end
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  endtask

  initial begin
    expItem_t it;
    int s, e, k;
    // R1: input high during reset has no effect
    dataIn = 1'b1;
    repeat (4) @(negedge clk);
    checkLevel(1'b0, "R1 reset");
    dataIn = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkLevel(1'b0, "R1 after reset");

    // rise code 3 -> 5 ticks, fall code 2 -> 2 ticks
    delayCfg = 8'h23;
    step(1, 20, 5, "R3 rise");
    step(0, 10, 2, "R7 fall");
    step(1, 3, -1, "R4 short");
    step(0, 4, -1, "R4");
    step(1, 5, -1, "R4 one short");
    step(0, 4, -1, "R4");
    checkLevel(1'b0, "R4 glitches blocked");
    step(1, 6, 5, "R3 exact hold");
    step(0, 2, -1, "R7 short low");
    step(1, 4, -1, "R7");
    checkLevel(1'b1, "R7 fall cancelled");
    step(0, 10, 2, "R7 fall");

    // rise 10 ticks, fall 500: abandoned rise, restart from zero
    delayCfg = 8'hF4;
    step(1, 5, -1, "R4 abandon");
    step(0, 3, -1, "R4");
    checkLevel(1'b0, "R4 no fall wait from low");
    step(1, 12, 10, "R4 restart count");
    delayCfg = 8'h04;
    step(0, 3, 0, "R6 zero fall");

    // zero codes
    delayCfg = 8'h00;
    step(1, 3, 0, "R5 zero rise");
    step(0, 3, 0, "R6 zero fall");
    step(1, 1, 0, "R5 one cycle pulse");
    step(0, 3, 0, "R6 after pulse");

    // largest and smallest codes
    delayCfg = 8'h1F;
    step(1, 502, 500, "R2 code 15");
    step(0, 5, 1, "R2 code 1");

    // R8: divided tick; rise code 2 -> 2 ticks
    delayCfg = 8'h02;
    tickMode = 1;
    s = cyc + 1;
    k = 0;
    e = s;
    while (k < 2) begin
      e++;
      if ((e % 3) == 0) k++;
    end
    it.edgeIdx = e; it.level = 1'b1; it.tag = "R8 divided tick";
    expQ.push_back(it);
    step(1, 12, -1, "R8");
    step(0, 4, 0, "R6 zero fall");

    // R8: no tick at all, then ticks resume
    delayCfg = 8'h22;
    tickMode = 2;
    step(1, 20, -1, "R8 stalled");
    checkLevel(1'b0, "R8 no tick no rise");
    tickMode = 0;
    step(1, 6, 1, "R8 resumed");
    tickMode = 2;
    step(0, 10, -1, "R8 stalled fall");
    checkLevel(1'b1, "R8 no tick no fall");
    tickMode = 0;
    step(0, 6, 1, "R8 fall resumed");
    finish();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: run did not end, expected completion");
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nChecks + 1, nFails);
      $finish;
    end
  end

endmodule